// File: doc/BRIEF.md
# Half-Word Multiply-Add Unit

This block is the integer datapath behind an extended multiply-add instruction. It receives three 32-bit operands (A, B, C) that were already fetched by the surrounding pipeline, together with a small control word. It takes one 16-bit half of A and one 16-bit half of B and multiplies them as unsigned values. The product can be moved up by 16 bit positions. A conditioned version of C is then added. Finally, the result can be merged with B so that the upper half of the result carries the low half of B. This is the building block for composing wide multiplies out of 16-bit pieces.

The source-form code tells the block where the operands came from. It matters in two places. When B was an immediate, only its low 16 bits are meaningful. When C came from a constant buffer, merging is not allowed. Operands are captured when the input strobe is high, and the result leaves the block on the next clock edge together with a result strobe. A mode value outside the defined set is flagged for that one result.

Top module: `hwma_unit`

## Requirements
- R1: With `hi_a_i`=1 the A multiplicand is A[31:16]; with `hi_a_i`=0 it is A[15:0].
- R2: With `hi_b_i`=1 the B multiplicand is B[31:16] of the effective B; with `hi_b_i`=0 it is B[15:0].
- R3: The two 16-bit multiplicands are multiplied unsigned into a 32-bit product. With `prod_shl_i`=1 the product is shifted left by 16, so only its low 16 bits remain, placed in bits 31:16.
- R4: `cmode_i` conditions C as follows: 0 passes C unchanged, 1 keeps C[15:0] zero-extended, 2 gives C logically shifted right by 16, and 3 gives C plus (effective B shifted left by 16), modulo 2^32.
- R5: The result before merge is the product plus the conditioned C, modulo 2^32, with the carry out dropped.
- R6: With `merge_i`=1, and merge permitted, the result is {effective B[15:0], sum[15:0]}.
- R7: Source-form code `src_form_i`=3 (C from a constant buffer) forces merge off whatever `merge_i` is. Codes 0 (register/register), 1 (B from constant) and 2 (immediate B) honour `merge_i`.
- R8: With `src_form_i`=2 the effective B is B[15:0] zero-extended, so B[31:16] has no effect on the multiplicand, on mode 3 or on the merge.
- R9: A `cmode_i` value of 4 to 7 passes C unchanged and raises `illegal_mode_o` for exactly the one result cycle of that operation.
- R10: The result appears with `res_valid_o` high exactly one clock after `in_valid_i` is sampled high. `res_valid_o` is low after a cycle with `in_valid_i` low. Synchronous active-high `rst` clears `res_valid_o` and `illegal_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and controls valid this cycle |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (only low 16 bits used in immediate form) |
| c_i | input | 32 | Addend C |
| hi_a_i | input | 1 | Select the upper half of A |
| hi_b_i | input | 1 | Select the upper half of B |
| prod_shl_i | input | 1 | Shift the product left by 16 |
| cmode_i | input | 3 | C conditioning mode (0..3 legal) |
| merge_i | input | 1 | Request the merge with B |
| src_form_i | input | 2 | Operand source form: 0 reg/reg, 1 B const, 2 B immediate, 3 C const |
| res_valid_o | output | 1 | Result valid strobe |
| res_o | output | 32 | Result |
| illegal_mode_o | output | 1 | Undefined mode used for this result |

## Verification
The bench builds the unit with its default data width of 32, so the half width is 16. This is the width at which the shift-by-16, the product truncation and the modulo-2^32 wrap of the add actually occur. With that width, every combination of the two half selects, product shift, all eight mode codes, merge request and all four source forms can be swept with random operands in a few hundred operations. Directed cases add all-ones operands to reach the carry out of the add, and immediate-form operands whose upper B bits are set to show that those bits are discarded.

// File: rtl/hwma_pkg.sv
package hwma_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned FORM_W = 2;

    typedef enum logic [FORM_W-1:0] {
        FORM_REG_REG  = 2'd0,
        FORM_B_CONST  = 2'd1,
        FORM_B_IMM    = 2'd2,
        FORM_C_CONST  = 2'd3
    } src_form_e;

    typedef enum logic [MODE_W-1:0] {
        CM_PASS  = 3'd0,
        CM_LOW   = 3'd1,
        CM_HIGH  = 3'd2,
        CM_BADD  = 3'd3
    } cmode_e;

endpackage

// File: rtl/hwma_halfsel.sv
module hwma_halfsel #(
    parameter int unsigned DW = 32,
    localparam int unsigned HW = DW / 2
) (
    input  logic [DW-1:0] word_i,
    input  logic          hi_i,
    output logic [HW-1:0] half_o
);
    always_comb begin
        if (hi_i) half_o = word_i[DW-1:HW];
        else      half_o = word_i[HW-1:0];
    end
endmodule

// File: rtl/hwma_cond.sv
module hwma_cond
    import hwma_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned HW = DW / 2
) (
    input  logic [DW-1:0]     c_i,
    input  logic [HW-1:0]     b_lo_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [DW-1:0]     c_o,
    output logic              bad_o
);
    always_comb begin
        c_o   = c_i;
        bad_o = 1'b0;
        case (mode_i)
            CM_PASS: c_o = c_i;
            CM_LOW:  c_o = {{HW{1'b0}}, c_i[HW-1:0]};
            CM_HIGH: c_o = {{HW{1'b0}}, c_i[DW-1:HW]};
            CM_BADD: c_o = c_i + {b_lo_i, {HW{1'b0}}};
            default: begin
                c_o   = c_i;
                bad_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hwma_merge.sv
module hwma_merge #(
    parameter int unsigned DW = 32,
    localparam int unsigned HW = DW / 2
) (
    input  logic [DW-1:0] sum_i,
    input  logic [HW-1:0] b_lo_i,
    input  logic          en_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        if (en_i) res_o = {b_lo_i, sum_i[HW-1:0]};
        else      res_o = sum_i;
    end
endmodule

// File: rtl/hwma_unit.sv
module hwma_unit
    import hwma_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned HW = DW / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [DW-1:0]     c_i,
    input  logic              hi_a_i,
    input  logic              hi_b_i,
    input  logic              prod_shl_i,
    input  logic [MODE_W-1:0] cmode_i,
    input  logic              merge_i,
    input  logic [FORM_W-1:0] src_form_i,
    output logic              res_valid_o,
    output logic [DW-1:0]     res_o,
    output logic              illegal_mode_o
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic          bad;
    } out_t;

    out_t st_d, st_q;

    logic [DW-1:0] b_eff;
    logic [HW-1:0] ma, mb;
    logic [DW-1:0] prod_raw, prod_adj, c_cond, sum, merged;
    logic          bad_mode, merge_en;
    src_form_e     form;

    assign form = src_form_e'(src_form_i);

    // Effective B: an immediate only carries its low half
    always_comb begin
        if (form == FORM_B_IMM) b_eff = {{HW{1'b0}}, b_i[HW-1:0]};
        else                    b_eff = b_i;
    end

    hwma_halfsel #(.DW(DW)) u_sel_a (.word_i(a_i),   .hi_i(hi_a_i), .half_o(ma));
    hwma_halfsel #(.DW(DW)) u_sel_b (.word_i(b_eff), .hi_i(hi_b_i), .half_o(mb));

    always_comb begin
        prod_raw = {{HW{1'b0}}, ma} * {{HW{1'b0}}, mb};
        if (prod_shl_i) prod_adj = prod_raw << HW;
        else            prod_adj = prod_raw;
    end

    hwma_cond #(.DW(DW)) u_cond (
        .c_i    (c_i),
        .b_lo_i (b_eff[HW-1:0]),
        .mode_i (cmode_i),
        .c_o    (c_cond),
        .bad_o  (bad_mode)
    );

    assign sum      = prod_adj + c_cond;
    assign merge_en = merge_i && (form != FORM_C_CONST);

    hwma_merge #(.DW(DW)) u_merge (
        .sum_i  (sum),
        .b_lo_i (b_eff[HW-1:0]),
        .en_i   (merge_en),
        .res_o  (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        st_d.bad = in_valid_i && bad_mode;
        if (in_valid_i) st_d.res = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o    = st_q.vld;
    assign res_o          = st_q.res;
    assign illegal_mode_o = st_q.bad;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> res_valid_o);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !res_valid_o);
    // R9
    bad_flag_valid_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_mode_o |-> res_valid_o);
    // R9
    bad_mode_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && cmode_i > MODE_W'(3)) |=> illegal_mode_o);
    // R6
    merge_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && merge_en) |=> (res_o[DW-1:HW] == $past(b_eff[HW-1:0])));
    // R7
    cconst_nomerge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && form == FORM_C_CONST) |=> (res_o == $past(sum)));
endmodule

// File: tb/sim_hwma_unit.sv
module sim_hwma_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] a = '0, b = '0, c = '0;
    logic        hia = 1'b0, hib = 1'b0, shl = 1'b0, mrg = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  src = '0;
    logic        vld_o, bad_o;
    logic [31:0] res_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hwma_unit u0 (
        .clk(clk), .rst(rst), .in_valid_i(in_valid),
        .a_i(a), .b_i(b), .c_i(c),
        .hi_a_i(hia), .hi_b_i(hib), .prod_shl_i(shl),
        .cmode_i(mode), .merge_i(mrg), .src_form_i(src),
        .res_valid_o(vld_o), .res_o(res_o), .illegal_mode_o(bad_o)
    );

    function automatic logic [32:0] ref_model(
        input logic [31:0] fa, input logic [31:0] fb, input logic [31:0] fc,
        input logic fha, input logic fhb, input logic fsh,
        input logic [2:0] fm, input logic fmg, input logic [1:0] fs);
        logic [31:0] be, ma, mb, p, cc, s;
        logic ill;
        be  = (fs == 2'd2) ? (fb & 32'h0000_FFFF) : fb;
        ma  = fha ? (fa >> 16) : (fa & 32'h0000_FFFF);
        mb  = fhb ? (be >> 16) : (be & 32'h0000_FFFF);
        p   = ma * mb;
        if (fsh) p = p << 16;
        ill = 1'b0;
        case (fm)
            3'd0: cc = fc;
            3'd1: cc = fc & 32'h0000_FFFF;
            3'd2: cc = fc >> 16;
            3'd3: cc = fc + (be << 16);
            default: begin cc = fc; ill = 1'b1; end
        endcase
        s = p + cc;
        if (fmg && fs != 2'd3) s = (be << 16) | (s & 32'h0000_FFFF);
        return {ill, s};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operation at negedge, check the registered result one clock later
    task automatic op(input string req,
                      input logic [31:0] ta, input logic [31:0] tb, input logic [31:0] tc,
                      input logic tha, input logic thb, input logic tsh,
                      input logic [2:0] tm, input logic tmg, input logic [1:0] ts);
        logic [32:0] e;
        a = ta; b = tb; c = tc; hia = tha; hib = thb; shl = tsh;
        mode = tm; mrg = tmg; src = ts; in_valid = 1'b1;
        e = ref_model(ta, tb, tc, tha, thb, tsh, tm, tmg, ts);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", {31'd0, vld_o}, 32'd1);
        check(req, "result", res_o, e[31:0]);
        check(req, "illegal", {31'd0, bad_o}, {31'd0, e[32]});
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10", "valid in reset", {31'd0, vld_o}, 32'd0);
        check("R10", "illegal in reset", {31'd0, bad_o}, 32'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        check("R10", "valid idle", {31'd0, vld_o}, 32'd0);
    endtask

    task automatic t_halves();
        // R1 R2: pick each half
        op("R1", 32'h0003_0005, 32'h0007_000B, 32'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0);
        op("R1", 32'h0003_0005, 32'h0007_000B, 32'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0);
        op("R2", 32'h0003_0005, 32'h0007_000B, 32'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 2'd0);
        op("R2", 32'h0003_0005, 32'h0007_000B, 32'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 2'd0);
    endtask

    task automatic t_product();
        // R3: FFFF*FFFF = FFFE0001, shifted keeps 0001 in the upper half
        op("R3", 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0);
        op("R3", 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0);
        check("R3", "shifted product literal", res_o, 32'h0001_0000);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++)
            op("R4", 32'h0000_0002, 32'h1234_0003, 32'hABCD_1234, 1'b0, 1'b0, 1'b0, 3'(m), 1'b0, 2'd0);
        // R5: wrap modulo 2^32
        op("R5", 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0);
        check("R5", "wrap literal", res_o, 32'h0000_FFFF);
    endtask

    task automatic t_merge();
        op("R6", 32'h0000_0010, 32'h9999_0020, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 2'd0);
        check("R6", "merge literal", res_o, 32'h0020_0201);
        op("R6", 32'h0000_0010, 32'h9999_0020, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 2'd1);
        op("R7", 32'h0000_0010, 32'h9999_0020, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 2'd3);
        check("R7", "no merge literal", res_o, 32'h0000_0201);
    endtask

    task automatic t_imm();
        // R8: upper B bits discarded in immediate form
        op("R8", 32'h0002_0000, 32'hFFFF_0004, 32'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 2'd2);
        check("R8", "hi-B imm literal", res_o, 32'd0);
        op("R8", 32'd0, 32'hFFFF_0004, 32'd1, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 2'd2);
        check("R8", "badd+merge literal", res_o, 32'h0004_0001);
    endtask

    task automatic t_illegal();
        for (int m = 4; m < 8; m++)
            op("R9", 32'h0000_0003, 32'h0000_0004, 32'h5555_AAAA, 1'b0, 1'b0, 1'b0, 3'(m), 1'b0, 2'd0);
        @(negedge clk);
        check("R9", "flag one cycle", {31'd0, bad_o}, 32'd0);
        check("R10", "valid drops", {31'd0, vld_o}, 32'd0);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 512; k++)
            op("R4", $urandom, $urandom, $urandom, k[0], k[1], k[2], k[5:3], k[6], k[8:7]);
    endtask

    task automatic t_reset_mid();
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R10", "reset clears valid", {31'd0, vld_o}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_halves();
        t_product();
        t_modes();
        t_merge();
        t_imm();
        t_illegal();
        t_sweep();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule